// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Access Port

This block is a serial test access port with a reduced instruction set. It runs on its own test clock `tck`. The serial mode input `tms` drives the usual sixteen-state controller, and the serial data input `tdi` feeds whichever register the active instruction selects. The port has four registers:

- a 3-bit instruction register;
- a 1-bit bypass register;
- a 32-bit identification register;
- a boundary register whose length is a parameter.

The boundary register samples a parallel vector that models the pad ring. The serial output `tdo` comes with an output enable `tdo_oe`, which stands in for the high-impedance pad. The output `pin_hiz` tells the functional pads to float.

There are four instructions: identification, sample, sample with pads floated, and bypass. The boundary register cannot be preloaded, so an update of a data scan has no effect. The controller's states are:

- Test-Logic-Reset (`ST_RESET`) and Run-Test/Idle (`ST_IDLE`);
- on the data side: Select (`ST_DR_SEL`), Capture (`ST_DR_CAP`), Shift (`ST_DR_SHIFT`), Exit1 (`ST_DR_EXIT1`), Pause (`ST_DR_PAUSE`), Exit2 (`ST_DR_EXIT2`) and Update (`ST_DR_UPD`);
- on the instruction side, the same seven states, named `ST_IR_*`.

The transitions follow the standard controller:

- Reset stays in Reset on `tms`=1 and goes to Idle on 0.
- Idle stays in Idle on 0 and goes to DR-Select on 1.
- DR-Select goes to IR-Select on 1 and to Capture on 0. IR-Select goes to Reset on 1 and to Capture on 0.
- Capture goes to Exit1 on 1 and to Shift on 0.
- Shift holds on 0 and goes to Exit1 on 1.
- Exit1 goes to Update on 1 and to Pause on 0.
- Pause holds on 0 and goes to Exit2 on 1.
- Exit2 goes to Update on 1 and back to Shift on 0.
- Update goes to DR-Select on 1 and to Idle on 0.

Top module: `scan_port`

## Requirements
- R1: While `rst_n` is low and after it is released, the controller is in Test-Logic-Reset, the active instruction is identification (001), `tdo_oe` is 0 and `pin_hiz` is 0.
- R2: Each time the controller enters Test-Logic-Reset, the active instruction becomes identification (001).
- R3: From any state, five consecutive rising `tck` edges with `tms`=1 put the controller in Test-Logic-Reset.
- R4: In Capture-IR the instruction shift register loads 001: its two low bits take the pattern 01 and bit 2 takes 0. During Shift-IR these bits leave on `tdo` LSB first.
- R5: `tms` and `tdi` are sampled on the rising `tck` edge. `tdo` and `tdo_oe` change on the falling edge, and `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.
- R6: Every shift moves `tdi` into the MSB and puts the LSB on `tdo`. Under identification (001), Capture-DR loads the 32-bit constant `ID_VAL`. Its default is 0x123451AB: bit 0 is 1 and bits 11..1 are 00011010101. Bit 0 shifts out first.
- R7: Under sample (100) or float-and-sample (010), Capture-DR loads `pin_in` into the boundary register. The register is `BSR_LEN` bits long, 70 by default (51 for the narrow configuration), and `pin_in` bit 0 shifts out first.
- R8: `pin_hiz` is 1 exactly while float-and-sample (010) is the active instruction.
- R9: Passing through Update-DR under sample (100) changes no output. Data shifted into the boundary register is not carried to any pad, and the next capture again shows `pin_in`.
- R10: Bypass (111) and the reserved codes 011, 101 and 110 all select the 1-bit bypass register, which delays `tdi` by one shift.
- R11: The bypass register captures 0 in Capture-DR, so the first bit out of a bypass scan is 0.
- R12: The active instruction changes only on the rising edge that leaves Update-IR, or on entry to Test-Logic-Reset. A code that has been shifted in but not yet updated has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| pin_in | input | BSR_LEN | Pad ring values sampled by the boundary register |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_oe | output | 1 | Drive enable for `tdo`; 0 means high-Z |
| pin_hiz | output | 1 | Forces the functional pads to high-Z |

## Verification
The hardest situation to reach from the ports is leaving the float-and-sample instruction through the five-edge `tms` reset while in the middle of a data shift. The bench loads 010, starts a boundary scan, abandons it with five `tms`-high steps, and then checks that `pin_hiz` has dropped and that a data scan with no instruction load returns the identification constant. A second subtle point is the gap between shifting a code in and updating it. The bench samples `pin_hiz` in Exit1-IR, after the float code has been shifted in but before Update-IR, and expects it still low.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int IR_W = 3;

    // instruction codes
    localparam logic [IR_W-1:0] OP_IDCODE   = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE_Z = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS   = 3'b111;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
        ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
    } tap_state_e;

    typedef enum logic [1:0] {
        SEL_BYP, SEL_ID, SEL_BSR
    } dr_sel_e;

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e st,
    output logic       cap_dr,
    output logic       shf_dr,
    output logic       cap_ir,
    output logic       shf_ir,
    output logic       upd_ir,
    output logic       enter_rst
);

    tap_state_e nxt;

    // state register
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) st <= ST_RESET;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     nxt = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: nxt = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   nxt = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: nxt = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        cap_dr    = (st == ST_DR_CAP);
        shf_dr    = (st == ST_DR_SHIFT);
        cap_ir    = (st == ST_IR_CAP);
        shf_ir    = (st == ST_IR_SHIFT);
        upd_ir    = (st == ST_IR_UPD);
        enter_rst = (nxt == ST_RESET);
    end

endmodule

// File: rtl/scan_ir.sv
module scan_ir
    import scan_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  logic            cap,
    input  logic            shf,
    input  logic            upd,
    input  logic            enter_rst,
    output logic            ir_lsb,
    output logic [IR_W-1:0] ir_act
);

    localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-2){1'b0}}, 2'b01};

    logic [IR_W-1:0] ir_sh;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)   ir_sh <= CAP_PAT;
        else if (cap) ir_sh <= CAP_PAT;
        else if (shf) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)         ir_act <= OP_IDCODE;
        else if (enter_rst) ir_act <= OP_IDCODE;
        else if (upd)       ir_act <= ir_sh;
    end

    assign ir_lsb = ir_sh[0];

endmodule

// File: rtl/scan_dr.sv
module scan_dr
    import scan_pkg::*;
#(
    parameter int          BSR_LEN = 70,
    parameter logic [31:0] ID_VAL  = 32'h1234_51AB
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tdi,
    input  logic               cap,
    input  logic               shf,
    input  logic [IR_W-1:0]    ir_act,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               dr_lsb
);

    dr_sel_e            sel;
    logic               byp_q;
    logic [31:0]        id_q;
    logic [BSR_LEN-1:0] bsr_q;

    always_comb begin
        case (ir_act)
            OP_IDCODE:              sel = SEL_ID;
            OP_SAMPLE, OP_SAMPLE_Z: sel = SEL_BSR;
            default:                sel = SEL_BYP;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            byp_q <= 1'b0;
            id_q  <= '0;
            bsr_q <= '0;
        end else begin
            unique case (sel)
                SEL_BYP: begin
                    if (cap)      byp_q <= 1'b0;
                    else if (shf) byp_q <= tdi;
                end
                SEL_ID: begin
                    if (cap)      id_q <= ID_VAL;
                    else if (shf) id_q <= {tdi, id_q[31:1]};
                end
                SEL_BSR: begin
                    if (cap)      bsr_q <= pin_in;
                    else if (shf) bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ID:  dr_lsb = id_q[0];
            SEL_BSR: dr_lsb = bsr_q[0];
            default: dr_lsb = byp_q;
        endcase
    end

endmodule

// File: rtl/scan_port.sv
module scan_port
    import scan_pkg::*;
#(
    parameter int          BSR_LEN = 70,
    parameter logic [31:0] ID_VAL  = 32'h1234_51AB
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic               pin_hiz
);

    tap_state_e      tap_st;
    logic            cap_dr, shf_dr, cap_ir, shf_ir, upd_ir, enter_rst;
    logic            ir_lsb, dr_lsb;
    logic [IR_W-1:0] ir_act;

    scan_fsm i_fsm (
        .tck(tck), .rst_n(rst_n), .tms(tms), .st(tap_st),
        .cap_dr(cap_dr), .shf_dr(shf_dr), .cap_ir(cap_ir),
        .shf_ir(shf_ir), .upd_ir(upd_ir), .enter_rst(enter_rst)
    );

    scan_ir i_ir (
        .tck(tck), .rst_n(rst_n), .tdi(tdi), .cap(cap_ir), .shf(shf_ir),
        .upd(upd_ir), .enter_rst(enter_rst), .ir_lsb(ir_lsb), .ir_act(ir_act)
    );

    scan_dr #(.BSR_LEN(BSR_LEN), .ID_VAL(ID_VAL)) i_dr (
        .tck(tck), .rst_n(rst_n), .tdi(tdi), .cap(cap_dr), .shf(shf_dr),
        .ir_act(ir_act), .pin_in(pin_in), .dr_lsb(dr_lsb)
    );

    // serial output retimed on the falling edge
    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= shf_ir | shf_dr;
            tdo    <= shf_ir ? ir_lsb : (shf_dr ? dr_lsb : 1'b0);
        end
    end

    assign pin_hiz = (ir_act == OP_SAMPLE_Z);

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
    import scan_pkg::*;
(
    input logic            tck,
    input logic            rst_n,
    input logic            tms,
    input logic            tdo_oe,
    input logic            pin_hiz,
    input tap_state_e      st,
    input logic [IR_W-1:0] ir
);

    logic [2:0] hi_cnt;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)               hi_cnt <= 3'd0;
        else if (!tms)            hi_cnt <= 3'd0;
        else if (hi_cnt != 3'd5)  hi_cnt <= hi_cnt + 3'd1;
    end

    // R3
    five_high_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (hi_cnt == 3'd5) |-> (st == ST_RESET));

    // R2
    reset_idcode_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (st == ST_RESET) |-> (ir == OP_IDCODE));

    // R12
    ir_update_only_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !$stable(ir) |-> (($past(st) == ST_IR_UPD) || (st == ST_RESET)));

    // R5
    tdo_oe_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe == ((st == ST_DR_SHIFT) || (st == ST_IR_SHIFT)));

    // R8
    hiz_rise_chk: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(pin_hiz) |-> ($past(st) == ST_IR_UPD));

endmodule

bind scan_port scan_port_chk i_chk (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdo_oe(tdo_oe),
    .pin_hiz(pin_hiz), .st(tap_st), .ir(ir_act)
);

// File: tb/test_scan_port.sv
module test_scan_port;

    localparam int          BL  = 70;
    localparam logic [31:0] IDV = 32'h1234_51AB;

    logic          tck = 1'b0;
    logic          rst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic [BL-1:0] pin_in = '0;
    logic          tdo, tdo_oe, pin_hiz;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic  b;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    logic obs_q[$];
    event obs_ev;
    logic oe_seen;

    scan_port #(.BSR_LEN(BL), .ID_VAL(IDV)) i_scan_port (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .pin_hiz(pin_hiz)
    );

    always #2 tck = ~tck;

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares observed tdo bits with expected items
    initial begin
        forever begin
            @(obs_ev);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                logic o;
                exp_t e;
                o = obs_q.pop_front();
                e = exp_q.pop_front();
                check(o === e.b, e.tag, {127'b0, o}, {127'b0, e.b});
            end
        end
    end

    // one tck cycle: sample tdo after the falling edge, drive, wait rising edge
    task automatic step(input logic t, input logic d, output logic seen);
        @(negedge tck);
        #1;
        seen    = tdo;
        oe_seen = tdo_oe;
        tms     = t;
        tdi     = d;
        @(posedge tck);
        #1;
    endtask

    task automatic walk(input logic t);
        logic s;
        step(t, 1'b0, s);
    endtask

    // from idle: scan n bits, expecting exp LSB first; ends in idle
    task automatic scan_dr(input int n, input logic [127:0] din, input logic [127:0] exp, input string tag);
        logic b;
        walk(1); walk(0); walk(0);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back('{exp[i], tag});
            step(i == n - 1, din[i], b);
            if (i == 0) check(oe_seen === 1'b1, "R5 tdo_oe in shift", {127'b0, oe_seen}, 128'd1);
            obs_q.push_back(b);
            ->obs_ev;
        end
        walk(1); walk(0);
    endtask

    // from idle: load an instruction; reports pin_hiz seen before Update-IR
    task automatic load_ir(input logic [2:0] code, output logic hiz_pre);
        logic b;
        walk(1); walk(1); walk(0); walk(0);
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back('{(i == 0), "R4 capture-IR pattern"});
            step(i == 2, code[i], b);
            obs_q.push_back(b);
            ->obs_ev;
        end
        hiz_pre = pin_hiz;
        walk(1); walk(0);
    endtask

    initial begin
        #800000;
        $display("FAIL watchdog expired");
        tests++;
        fails++;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic          hz;
        logic [BL-1:0] pat_a, pat_b, shin;
        logic [127:0]  bexp, bdin;

        pat_a = {6'h2A, 64'hDEAD_BEEF_0123_4567};
        pat_b = {6'h15, 64'h0F1E_2D3C_4B5A_6978};
        shin  = {6'h3F, 64'hFFFF_0000_FFFF_0000};

        #9;
        check(tdo_oe === 1'b0, "R1 tdo_oe in reset", {127'b0, tdo_oe}, 128'd0);
        check(pin_hiz === 1'b0, "R1 pin_hiz in reset", {127'b0, pin_hiz}, 128'd0);
        rst_n = 1'b1;
        walk(1); walk(1);
        check(oe_seen === 1'b0, "R5 tdo_oe outside shift", {127'b0, oe_seen}, 128'd0);
        walk(0);

        // R1 R6: identification after reset, no instruction load
        scan_dr(32, 128'h0, {96'h0, IDV}, "R6 ID after reset (R1)");
        check(IDV[0] == 1'b1 && IDV[11:1] == 11'b00011010101, "R6 vendor field", {116'b0, IDV[11:0]}, 128'h1AB);

        // R10 R11: bypass
        load_ir(3'b111, hz);
        bdin = 128'h00A5;
        bexp = {bdin[126:0], 1'b0};
        scan_dr(8, bdin, bexp, "R10 R11 bypass 111");

        // R10: reserved codes behave as bypass
        load_ir(3'b101, hz);
        bdin = 128'h0096;
        scan_dr(8, bdin, {bdin[126:0], 1'b0}, "R10 reserved 101");
        load_ir(3'b011, hz);
        bdin = 128'h00C3;
        scan_dr(8, bdin, {bdin[126:0], 1'b0}, "R10 reserved 011");
        load_ir(3'b110, hz);
        bdin = 128'h005A;
        scan_dr(8, bdin, {bdin[126:0], 1'b0}, "R10 reserved 110");

        // R7 R9: sample, no preload
        load_ir(3'b100, hz);
        check(pin_hiz === 1'b0, "R8 pin_hiz low under sample", {127'b0, pin_hiz}, 128'd0);
        pin_in = pat_a;
        scan_dr(BL, {58'b0, shin}, {58'b0, pat_a}, "R7 sample capture");
        check(pin_hiz === 1'b0 && tdo_oe === 1'b0, "R9 no output change after Update-DR",
              {126'b0, pin_hiz, tdo_oe}, 128'd0);
        pin_in = pat_b;
        scan_dr(BL, 128'h0, {58'b0, pat_b}, "R9 recapture shows pins not shifted data");

        // R12 R8: float-and-sample
        load_ir(3'b010, hz);
        check(hz === 1'b0, "R12 pin_hiz before Update-IR", {127'b0, hz}, 128'd0);
        check(pin_hiz === 1'b1, "R8 pin_hiz under float-and-sample", {127'b0, pin_hiz}, 128'd1);
        pin_in = pat_a;
        scan_dr(BL, 128'h0, {58'b0, pat_a}, "R7 float-and-sample capture");
        check(pin_hiz === 1'b1, "R8 pin_hiz held after data scan", {127'b0, pin_hiz}, 128'd1);

        // R3 R2: five tms-high edges out of the middle of a shift
        walk(1); walk(0); walk(0);
        walk(0); walk(0);
        for (int i = 0; i < 5; i++) walk(1);
        check(pin_hiz === 1'b0, "R2 R3 instruction reset by five tms-high", {127'b0, pin_hiz}, 128'd0);
        walk(0);
        scan_dr(32, 128'h0, {96'h0, IDV}, "R2 ID after tms reset");

        // R5: tdo_oe low back in idle
        walk(0);
        check(oe_seen === 1'b0, "R5 tdo_oe in idle", {127'b0, oe_seen}, 128'd0);

        #20;
        ->obs_ev;
        #4;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule